// File: doc/BRIEF.md
# Prioritized Two-Line Interrupt Controller

This block collects up to 32 interrupt source lines and presents them to a processor over two request outputs: a normal interrupt line and a fast interrupt line. Each source line is passed through a synchronizer. A per-source configuration word then turns the line into a pending bit, either by latching rising edges or by following a high level. Software reads and writes the controller through a 16-bit register port that honours byte lanes. Through that port it can clear pending bits, block sources with mask bits, and set each source's priority, output routing and capture mode.

Each output line has its own arbiter. Among the unmasked pending sources routed to that line, the arbiter picks the one with the numerically smallest priority value. Once a winner is latched, its source number and the request output stay frozen. They change only when software sets that line's "new arbitration" bit in the control register. The controller then releases the line and arbitrates again on the next cycle.

Register map (halfword addresses): pending low `0x00`, pending high `0x02`, mask low `0x04`, mask high `0x06`, IRQ winner `0x08`, FIQ winner `0x0A`, control `0x0C` (write-only, reads 0), and the per-source configuration word for source n at `0x20 + 2*n`.

Top module: `prio_intc`

## Requirements
- R1: After reset, both mask registers read 0xFFFF, both pending registers read 0, every configuration word reads 0, both winner registers read 0, and `irq_o` and `fiq_o` are low.
- R2: In a configuration word, bit 1 selects the capture mode. With bit 1 = 1 (edge mode), a pending bit is set only on a rising edge of the synchronized source, and a source held high does not set the bit again after a clear. With bit 1 = 0 (level mode), the pending bit is set in every cycle the synchronized source is high.
- R3: Writing 0 to a pending bit clears it. Writing 1 leaves it unchanged. Byte lanes whose enable is low leave their 8 pending bits unchanged.
- R4: When a hardware set and a software clear hit the same pending bit in the same cycle, the bit ends up 1.
- R5: A source takes part in arbitration only if its pending bit is 1 and its mask bit is 0. A mask bit of 1 keeps a pending source from raising either output.
- R6: The arbiter picks the eligible source with the smallest priority value, taken from configuration bits 6:2. On equal priority, the lowest source number wins.
- R7: Configuration bit 0 routes a source to the fast line (1) or the normal line (0). Each line arbitrates only over the sources routed to it.
- R8: While a line's output is high, its winner number and output stay unchanged until that line's new-arbitration bit is written. This holds even if the winner's pending bit is cleared or a higher-priority source becomes pending.
- R9: Writing 1 to control bit 0 (normal line) or control bit 1 (fast line), with byte lane 0 enabled, drops that output at the same clock edge and leaves the other line untouched. The line arbitrates again on the following edge.
- R10: Sources 16..31 occupy bit n-16 of the high pending and mask registers. Winner numbers occupy bits 4:0 of their registers. A configuration word stores only bits 6:0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address (bit 0 ignored) |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that a control-register write counts as an acknowledge only when lane 0 is enabled. They also assume that a source line is not changed again until its earlier edge has passed through the synchronizer. The directed stimulus changes sources only on falling clock edges and waits several cycles before the next change, so every level and edge reaches the pending logic as intended. Bus writes are single-cycle strobes issued one after another, so no two register accesses overlap.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int PRIO_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   src_i,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_be,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int NSRC  = 32;
  localparam int NUM_W = $clog2(NSRC);
  localparam int LVL_W = PRIO_W + 2;
  localparam logic [AW-1:0] A_PEND_LO = AW'(8'h00);
  localparam logic [AW-1:0] A_PEND_HI = AW'(8'h02);
  localparam logic [AW-1:0] A_MASK_LO = AW'(8'h04);
  localparam logic [AW-1:0] A_MASK_HI = AW'(8'h06);
  localparam logic [AW-1:0] A_IRQ_NUM = AW'(8'h08);
  localparam logic [AW-1:0] A_FIQ_NUM = AW'(8'h0A);
  localparam logic [AW-1:0] A_CTRL    = AW'(8'h0C);
  localparam logic [AW-1:0] A_LVL     = AW'(8'h20);
  localparam logic [AW-1:0] A_LVL_END = AW'(32'h20 + 2 * NSRC);

  logic [NSRC-1:0]   sync_q [SYNC_STAGES];
  logic [NSRC-1:0]   prev_q, pend_q, mask_q, src_s, hw_set, elig, route_v, edge_v;
  logic [LVL_W-1:0]  lvl_q  [NSRC];
  logic [PRIO_W-1:0] prio_v [NSRC];
  logic [1:0]        act_q, found, ack;
  logic [NUM_W-1:0]  num_q  [2];
  logic [NUM_W-1:0]  best_n [2];
  logic [PRIO_W-1:0] best_p [2];

  wire            wr_en   = bus_sel & bus_wr;
  wire [AW-1:0]   addr_h  = {bus_addr[AW-1:1], 1'b0};
  wire [15:0]     lane    = {{8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [15:0]     clr_lo  = (wr_en && addr_h == A_PEND_LO) ? (lane & ~bus_wdata) : 16'h0;
  wire [15:0]     clr_hi  = (wr_en && addr_h == A_PEND_HI) ? (lane & ~bus_wdata) : 16'h0;
  wire            lvl_hit = (addr_h >= A_LVL) && (addr_h < A_LVL_END);
  wire [AW-1:0]   lvl_off = addr_h - A_LVL;
  wire [NUM_W-1:0] lvl_idx = lvl_off[NUM_W:1];
  wire [15:0]     lvl_cur = 16'(lvl_q[lvl_idx]);
  wire [15:0]     lvl_new = (lvl_cur & ~lane) | (bus_wdata & lane);

  assign src_s = sync_q[SYNC_STAGES-1];
  assign elig  = pend_q & ~mask_q;
  assign ack   = (wr_en && addr_h == A_CTRL && bus_be[0]) ? bus_wdata[1:0] : 2'b00;
  assign irq_o = act_q[0];
  assign fiq_o = act_q[1];

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      route_v[i] = lvl_q[i][0];
      edge_v[i]  = lvl_q[i][1];
      prio_v[i]  = lvl_q[i][LVL_W-1:2];
      hw_set[i]  = edge_v[i] ? (src_s[i] & ~prev_q[i]) : src_s[i];
    end
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      found[l]  = 1'b0;
      best_n[l] = '0;
      best_p[l] = '1;
      for (int i = 0; i < NSRC; i++) begin
        if (elig[i] && route_v[i] == 1'(l) && (!found[l] || prio_v[i] < best_p[l])) begin
          found[l]  = 1'b1;
          best_n[l] = NUM_W'(i);
          best_p[l] = prio_v[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= src_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~{clr_hi, clr_lo}) | hw_set;
      if (wr_en && addr_h == A_MASK_LO)
        mask_q[15:0] <= (mask_q[15:0] & ~lane) | (bus_wdata & lane);
      if (wr_en && addr_h == A_MASK_HI)
        mask_q[31:16] <= (mask_q[31:16] & ~lane) | (bus_wdata & lane);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else if (wr_en && lvl_hit) begin
      lvl_q[lvl_idx] <= lvl_new[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int l = 0; l < 2; l++) num_q[l] <= '0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (ack[l]) begin
          act_q[l] <= 1'b0;
        end else if (!act_q[l] && found[l]) begin
          act_q[l] <= 1'b1;
          num_q[l] <= best_n[l];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr_h)
      A_PEND_LO: bus_rdata = pend_q[15:0];
      A_PEND_HI: bus_rdata = pend_q[31:16];
      A_MASK_LO: bus_rdata = mask_q[15:0];
      A_MASK_HI: bus_rdata = mask_q[31:16];
      A_IRQ_NUM: bus_rdata = 16'(num_q[0]);
      A_FIQ_NUM: bus_rdata = 16'(num_q[1]);
      default:   if (lvl_hit) bus_rdata = lvl_cur;
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int AW    = 8,
  parameter int NUM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [1:0]       bus_be,
  input logic [15:0]      bus_wdata,
  input logic [31:0]      src_s,
  input logic [31:0]      prev_q,
  input logic [31:0]      edge_v,
  input logic [31:0]      route_v,
  input logic [31:0]      mask_q,
  input logic [31:0]      pend_q,
  input logic [NUM_W-1:0] irq_num,
  input logic [NUM_W-1:0] fiq_num,
  input logic             irq_o,
  input logic             fiq_o
);
  wire ctl_wr  = bus_sel && bus_wr && bus_be[0] && ({bus_addr[AW-1:1], 1'b0} == AW'(8'h0C));
  wire ack_irq = ctl_wr && bus_wdata[0];
  wire ack_fiq = ctl_wr && bus_wdata[1];

  logic [31:0] mask_d, pend_d, route_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_d  <= '1;
      pend_d  <= '0;
      route_d <= '0;
    end else begin
      mask_d  <= mask_q;
      pend_d  <= pend_q;
      route_d <= route_v;
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v[i] ? (src_s[i] && !prev_q[i]) : src_s[i]) |=> pend_q[i]);
  end

  a_r8_irq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_irq) |=> (irq_o && $stable(irq_num)));
  a_r8_fiq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !ack_fiq) |=> (fiq_o && $stable(fiq_num)));
  a_r9_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !irq_o);
  a_r9_fiq_release: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fiq |=> !fiq_o);
  a_r5_irq_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (!mask_d[irq_num] && pend_d[irq_num]));
  a_r5_fiq_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> (!mask_d[fiq_num] && pend_d[fiq_num]));
  a_r7_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !route_d[irq_num]);
  a_r7_fiq_route: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> route_d[fiq_num]);
endmodule

bind prio_intc prio_intc_chk #(.AW(AW), .NUM_W(5)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .src_s     (src_s),
  .prev_q    (prev_q),
  .edge_v    (edge_v),
  .route_v   (route_v),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .irq_num   (num_q[0]),
  .fiq_num   (num_q[1]),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  be = 2'b11;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_be(be), .bus_wdata(wd), .bus_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] b = 2'b11);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wd = d; be = b;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; be = 2'b11;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    settle();
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [15:0] e);
    logic [15:0] d;
    bus_read(a, d);
    check(req, {16'h0, d}, {16'h0, e});
  endtask

  task automatic cleanup();
    drive_src('0);
    bus_write(8'h04, 16'hFFFF);
    bus_write(8'h06, 16'hFFFF);
    bus_write(8'h00, 16'h0000);
    bus_write(8'h02, 16'h0000);
    bus_write(8'h0C, 16'h0003);
    settle();
  endtask

  task automatic t_reset();
    expect_reg("R1 mask lo", 8'h04, 16'hFFFF);
    expect_reg("R1 mask hi", 8'h06, 16'hFFFF);
    expect_reg("R1 pend lo", 8'h00, 16'h0000);
    expect_reg("R1 pend hi", 8'h02, 16'h0000);
    expect_reg("R1 irq num", 8'h08, 16'h0000);
    expect_reg("R1 fiq num", 8'h0A, 16'h0000);
    expect_reg("R1 cfg 5", 8'h2A, 16'h0000);
    check("R1 irq_o", {31'h0, irq}, 32'h0);
    check("R1 fiq_o", {31'h0, fiq}, 32'h0);
  endtask

  task automatic t_capture();
    bus_write(8'h26, 16'h0002);
    drive_src(32'h0000_0008);
    expect_reg("R2 edge sets pending", 8'h00, 16'h0008);
    bus_write(8'h00, 16'hFFF7);
    expect_reg("R2 edge held high no reset", 8'h00, 16'h0000);
    drive_src(32'h0000_0018);
    expect_reg("R2 level sets pending", 8'h00, 16'h0010);
    bus_write(8'h00, 16'h0000);
    expect_reg("R4 set beats clear", 8'h00, 16'h0010);
    drive_src(32'h0);
    expect_reg("R2 level bit held after drop", 8'h00, 16'h0010);
    bus_write(8'h00, 16'hFFFF);
    expect_reg("R3 ones leave pending", 8'h00, 16'h0010);
    bus_write(8'h00, 16'h0000, 2'b10);
    expect_reg("R3 disabled lane kept", 8'h00, 16'h0010);
    bus_write(8'h00, 16'h0000, 2'b01);
    expect_reg("R3 zero clears", 8'h00, 16'h0000);
    check("R5 masked no irq", {31'h0, irq}, 32'h0);
    cleanup();
  endtask

  task automatic t_cfg_word();
    bus_write(8'h5C, 16'hFFFF);
    expect_reg("R10 cfg stores 7 bits", 8'h5C, 16'h007F);
    bus_write(8'h5C, 16'h0000, 2'b10);
    expect_reg("R10 cfg upper lane", 8'h5C, 16'h007F);
    bus_write(8'h5C, 16'h0000, 2'b01);
    expect_reg("R10 cfg cleared", 8'h5C, 16'h0000);
  endtask

  task automatic t_mask();
    drive_src(32'h0010_0000);
    expect_reg("R10 src20 in pend hi bit4", 8'h02, 16'h0010);
    check("R5 masked pending no irq", {31'h0, irq}, 32'h0);
    bus_write(8'h06, 16'hFFEF);
    settle();
    check("R5 unmasked raises irq", {31'h0, irq}, 32'h1);
    check("R7 irq source not on fiq", {31'h0, fiq}, 32'h0);
    expect_reg("R10 irq num 20", 8'h08, 16'd20);
    drive_src(32'h0);
    bus_write(8'h02, 16'hFFEF);
    bus_write(8'h0C, 16'h0001);
    check("R9 ack drops irq", {31'h0, irq}, 32'h0);
    cleanup();
  endtask

  task automatic t_prio();
    bus_write(8'h2E, 16'd36);
    bus_write(8'h24, 16'd12);
    bus_write(8'h38, 16'd12);
    bus_write(8'h04, 16'hEF7A);
    drive_src(32'h0000_1084);
    check("R6 irq asserted", {31'h0, irq}, 32'h1);
    expect_reg("R6 tie to lowest index", 8'h08, 16'd2);
    drive_src(32'h0000_1080);
    bus_write(8'h00, 16'hFFFB);
    drive_src(32'h0000_1081);
    expect_reg("R8 frozen after clear and higher prio", 8'h08, 16'd2);
    check("R8 irq held", {31'h0, irq}, 32'h1);
    drive_src(32'h0000_1080);
    bus_write(8'h00, 16'hFFFE);
    bus_write(8'h0C, 16'h0001);
    check("R9 ack drops irq", {31'h0, irq}, 32'h0);
    settle();
    expect_reg("R6 next by priority", 8'h08, 16'd12);
    drive_src(32'h0000_0080);
    bus_write(8'h00, 16'hEFFF);
    bus_write(8'h0C, 16'h0001);
    settle();
    expect_reg("R6 lowest remaining", 8'h08, 16'd7);
    cleanup();
  endtask

  task automatic t_route();
    bus_write(8'h52, 16'd5);
    bus_write(8'h32, 16'd24);
    bus_write(8'h04, 16'hFDFF);
    bus_write(8'h06, 16'hFDFF);
    drive_src(32'h0200_0200);
    check("R7 fiq asserted", {31'h0, fiq}, 32'h1);
    expect_reg("R7 fiq num 25", 8'h0A, 16'd25);
    check("R7 irq asserted", {31'h0, irq}, 32'h1);
    expect_reg("R7 irq num 9", 8'h08, 16'd9);
    bus_write(8'h0C, 16'h0002);
    check("R9 fiq ack drops fiq", {31'h0, fiq}, 32'h0);
    check("R9 irq untouched", {31'h0, irq}, 32'h1);
    settle();
    check("R9 fiq rearbitrated", {31'h0, fiq}, 32'h1);
    expect_reg("R9 fiq num again", 8'h0A, 16'd25);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_cfg_word();
    t_mask();
    t_prio();
    t_route();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule